// File: doc/BRIEF.md
# Two-Wire Bus Read Slave with Event Status Codes

This block is the slave side of a two-wire (I2C) bus for read transfers only. A bus master addresses it with a 7-bit address and the read direction bit. The slave acknowledges the address and then shifts out bytes that a local host has written into its data register. After each bus event the slave stores a byte-wide status code, raises an interrupt flag and holds SCL low until the host responds. The host responds by loading the next byte and writing a control word that clears the flag.

The host sees four things: a data register, a control register with an acknowledge-enable bit, a stop-request bit and a flag-clear strobe, a status code, and the flag. The slave watches for a START or STOP condition that lands inside an address byte, a data byte or an acknowledge slot. It reports such a condition as a bus error. The host clears a bus error by clearing the flag with the stop-request bit set. The slave then drops back to the not-addressed state without driving anything onto the bus.

Both bus lines are open-drain. Each is modelled as an input and a pull-low enable. The inputs pass through a synchronizer before edge detection.

Top module: `i2c_tx_slave`

## Requirements
- R1: After reset the flag is 0, the status reads 0xF8, both pull-low enables are 0, and acknowledge-enable and stop-request are both 0.
- R2: An address byte is received MSB first, with bit 0 (the 8th bit) as the direction bit, where 1 means read. The slave pulls SDA low in the 9th bit slot only when the upper seven bits equal OWN_ADDR, the direction bit is 1 and acknowledge-enable is 1. For any other address byte it raises no flag and the status stays 0xF8.
- R3: After the address is acknowledged, the status is 0xA8 and the flag is set. While the flag is set the slave holds SCL low and leaves SDA released. The flag stays set until the host clears it.
- R4: When the host clears the flag in order to continue, the data register is copied into the shifter and sent MSB first. SDA changes only while SCL is low.
- R5: If the master acknowledges a sent byte (SDA low at the 9th rising edge), the status becomes 0xB8 with the flag set. If the master does not acknowledge it, the status becomes 0xC0.
- R6: A byte that was loaded while acknowledge-enable was 0 is the last byte. If the master acknowledges the last byte, the status becomes 0xC8. After the flag is cleared, the slave is not addressed and leaves SDA released, so further bytes read 0xFF and set no flag.
- R7: After clearing the flag from 0xC0 or 0xC8, SDA stays released and a new START with the slave's own address is served from the beginning.
- R8: While the flag is clear the status reads 0xF8. Every status code has its low three bits equal to zero.
- R9: A START or STOP that occurs during an address bit, a data bit or an acknowledge bit sets the status to 0x00 and raises the flag.
- R10: Writing flag-clear together with stop-request returns the slave to not-addressed. On the next cycle the flag is 0, stop-request reads 0 and both lines are released. Acknowledge-enable keeps the value written, and the slave drives no STOP afterwards.
- R11: In the bus-error state, writing flag-clear without stop-request has no effect: the flag stays set and the status stays 0x00.
- R12: With acknowledge-enable at 0, even the slave's own read address is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sensed level of the SCL line |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclOe | output | 1 | Pull SCL low (clock stretch) |
| sdaOe | output | 1 | Pull SDA low |
| dataWe | input | 1 | Write strobe for the data register |
| dataIn | input | 8 | Byte to send next |
| ctrlWe | input | 1 | Write strobe for the control word |
| ctrlAckEn | input | 1 | Acknowledge-enable value to write |
| ctrlStop | input | 1 | Stop-request value to write |
| ctrlIntClr | input | 1 | Write 1 to clear the flag |
| ackEnQ | output | 1 | Current acknowledge-enable |
| stopQ | output | 1 | Current stop-request |
| statusQ | output | 8 | Status code, 0xF8 while the flag is clear |
| intFlag | output | 1 | Interrupt flag |

## Verification
The bench builds the slave with OWN_ADDR = 7'h5A and SYNC_STAGES = 2. Because the address space is only 7 bits, the bench can sweep every address with both direction bits and compare the acknowledge against the arithmetic match rule. Data bytes come from a linear formula and are checked bit by bit at the master. The bench also runs the acknowledged, not-acknowledged and last-byte endings, and injects a START and a STOP inside frames to exercise error recovery.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [BYTE_W-1:0] STS_ADDR_ACKED  = 8'hA8;
  localparam logic [BYTE_W-1:0] STS_BYTE_ACKED  = 8'hB8;
  localparam logic [BYTE_W-1:0] STS_BYTE_NACKED = 8'hC0;
  localparam logic [BYTE_W-1:0] STS_LAST_ACKED  = 8'hC8;
  localparam logic [BYTE_W-1:0] STS_NO_INFO     = 8'hF8;
  localparam logic [BYTE_W-1:0] STS_BUS_ERROR   = 8'h00;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_TX, S_TACK, S_HOLD, S_ERR
  } fsm_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadShift;
    logic shiftTx;
    logic shiftRx;
    logic clrCnt;
  } strobe_t;

  // bus events and datapath state seen by control
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
    logic sdaNow;
    logic cntFull;
    logic addrHit;
    logic rdBit;
    logic txBit;
  } busev_t;
endpackage

// File: rtl/i2c_tx_datapath.sv
module i2c_tx_datapath
  import i2c_tx_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OWN_ADDR    = 7'h5A,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              dataWe,
  input  logic [BYTE_W-1:0] dataIn,
  input  strobe_t           strb,
  output busev_t            ev
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclNow, sdaNow;
  logic [BYTE_W-1:0] shiftReg, dataReg;
  logic [CNT_W-1:0]  bitCnt;

  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync[0] <= sclIn;
      sdaSync[0] <= sdaIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sclSync[i] <= sclSync[i-1];
        sdaSync[i] <= sdaSync[i-1];
      end
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
      dataReg  <= '0;
      bitCnt   <= '0;
    end else begin
      if (dataWe) dataReg <= dataIn;
      if (strb.clrCnt) bitCnt <= '0;
      else if (strb.shiftRx || strb.shiftTx) bitCnt <= bitCnt + 1'b1;
      if (strb.loadShift) shiftReg <= dataReg;
      else if (strb.shiftRx) shiftReg <= {shiftReg[BYTE_W-2:0], sdaNow};
      else if (strb.shiftTx) shiftReg <= {shiftReg[BYTE_W-2:0], 1'b1};
    end
  end

  always_comb begin
    ev.start   = sclNow && sclPrev && sdaPrev && !sdaNow;
    ev.stop    = sclNow && sclPrev && !sdaPrev && sdaNow;
    ev.sclRise = sclNow && !sclPrev;
    ev.sclFall = !sclNow && sclPrev;
    ev.sdaNow  = sdaNow;
    ev.cntFull = (bitCnt == CNT_W'(BYTE_W));
    ev.addrHit = (shiftReg[BYTE_W-1 -: ADDR_W] == OWN_ADDR);
    ev.rdBit   = shiftReg[0];
    ev.txBit   = shiftReg[BYTE_W-1];
  end
endmodule

// File: rtl/i2c_tx_ctrl.sv
module i2c_tx_ctrl
  import i2c_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busev_t            ev,
  input  logic              ctrlWe,
  input  logic              ctrlAckEn,
  input  logic              ctrlStop,
  input  logic              ctrlIntClr,
  output strobe_t           strb,
  output logic              sdaOe,
  output logic              sclOe,
  output logic              ackEnQ,
  output logic              stopQ,
  output logic [BYTE_W-1:0] statusQ,
  output logic              intFlag
);
  fsm_e state, stateN;
  logic [BYTE_W-1:0] statusR, statusN;
  logic flagQ, flagN, ackEnN, stopN, lastQ, lastN, ackRcvQ, ackRcvN, goTxQ, goTxN;
  logic clrEv, busy;

  always_comb begin
    stateN  = state;
    statusN = statusR;
    flagN   = flagQ;
    ackEnN  = ackEnQ;
    stopN   = stopQ;
    lastN   = lastQ;
    ackRcvN = ackRcvQ;
    goTxN   = goTxQ;
    strb    = '0;
    clrEv   = ctrlWe && ctrlIntClr && flagQ;
    busy    = (state == S_ADDR) || (state == S_AACK) || (state == S_TX) || (state == S_TACK);
    if (ctrlWe) begin
      ackEnN = ctrlAckEn;
      stopN  = ctrlStop;
    end
    if (busy && (ev.start || ev.stop)) begin
      stateN  = S_ERR;
      statusN = STS_BUS_ERROR;
      flagN   = 1'b1;
    end else begin
      case (state)
        S_IDLE: if (ev.start) begin
          stateN = S_ADDR;
          strb.clrCnt = 1'b1;
        end
        S_ADDR: begin
          if (ev.cntFull) begin
            if (!(ev.addrHit && ev.rdBit && ackEnQ)) stateN = S_IDLE;
            else if (ev.sclFall) stateN = S_AACK;
          end else if (ev.sclRise) begin
            strb.shiftRx = 1'b1;
          end
        end
        S_AACK: if (ev.sclFall) begin
          stateN  = S_HOLD;
          statusN = STS_ADDR_ACKED;
          flagN   = 1'b1;
          goTxN   = 1'b1;
        end
        S_TX: begin
          if (ev.cntFull) stateN = S_TACK;
          else if (ev.sclFall) strb.shiftTx = 1'b1;
        end
        S_TACK: begin
          if (ev.sclRise) ackRcvN = !ev.sdaNow;
          if (ev.sclFall) begin
            stateN  = S_HOLD;
            flagN   = 1'b1;
            statusN = !ackRcvQ ? STS_BYTE_NACKED : (lastQ ? STS_LAST_ACKED : STS_BYTE_ACKED);
            goTxN   = ackRcvQ && !lastQ;
          end
        end
        S_HOLD: if (clrEv) begin
          flagN = 1'b0;
          if (ctrlStop) begin
            stateN = S_IDLE;
            stopN  = 1'b0;
          end else if (goTxQ) begin
            stateN         = S_TX;
            strb.loadShift = 1'b1;
            strb.clrCnt    = 1'b1;
            lastN          = !ctrlAckEn;
          end else begin
            stateN = S_IDLE;
          end
        end
        S_ERR: if (clrEv && ctrlStop) begin
          flagN  = 1'b0;
          stateN = S_IDLE;
          stopN  = 1'b0;
        end
        default: stateN = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      statusR <= STS_NO_INFO;
      flagQ   <= 1'b0;
      ackEnQ  <= 1'b0;
      stopQ   <= 1'b0;
      lastQ   <= 1'b0;
      ackRcvQ <= 1'b0;
      goTxQ   <= 1'b0;
    end else begin
      state   <= stateN;
      statusR <= statusN;
      flagQ   <= flagN;
      ackEnQ  <= ackEnN;
      stopQ   <= stopN;
      lastQ   <= lastN;
      ackRcvQ <= ackRcvN;
      goTxQ   <= goTxN;
    end
  end

  assign intFlag = flagQ;
  assign sclOe   = flagQ;
  assign statusQ = flagQ ? statusR : STS_NO_INFO;
  assign sdaOe   = (state == S_AACK) || ((state == S_TX) && !ev.txBit);
endmodule

// File: rtl/i2c_tx_slave.sv
module i2c_tx_slave
  import i2c_tx_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OWN_ADDR    = 7'h5A,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  input  logic              dataWe,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              ctrlWe,
  input  logic              ctrlAckEn,
  input  logic              ctrlStop,
  input  logic              ctrlIntClr,
  output logic              ackEnQ,
  output logic              stopQ,
  output logic [BYTE_W-1:0] statusQ,
  output logic              intFlag
);
  strobe_t strb;
  busev_t  ev;

  i2c_tx_datapath #(.OWN_ADDR(OWN_ADDR), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .dataWe(dataWe), .dataIn(dataIn), .strb(strb), .ev(ev)
  );

  i2c_tx_ctrl ctl_i (
    .clk(clk), .rstN(rstN), .ev(ev),
    .ctrlWe(ctrlWe), .ctrlAckEn(ctrlAckEn), .ctrlStop(ctrlStop), .ctrlIntClr(ctrlIntClr),
    .strb(strb), .sdaOe(sdaOe), .sclOe(sclOe), .ackEnQ(ackEnQ), .stopQ(stopQ),
    .statusQ(statusQ), .intFlag(intFlag)
  );
endmodule

// File: rtl/i2c_tx_slave_chk.sv
module i2c_tx_slave_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclOe,
  input logic       sdaOe,
  input logic       ctrlWe,
  input logic       ctrlStop,
  input logic       ctrlIntClr,
  input logic       stopQ,
  input logic [7:0] statusQ,
  input logic       intFlag
);
  // R8: a raised flag always carries a real code with zero low bits
  p_flag_code_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFlag) |-> (statusQ[2:0] == 3'b000 && statusQ != 8'hF8));

  // R3: flag persists until the host clears it; SDA released meanwhile
  p_flag_persist_r3: assert property (@(posedge clk) disable iff (!rstN)
    (intFlag && !(ctrlWe && ctrlIntClr)) |=> intFlag);
  p_sda_free_r3: assert property (@(posedge clk) disable iff (!rstN)
    intFlag |-> !sdaOe);

  // R2: the address-acknowledged code follows a driven ACK slot
  p_ack_drive_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(intFlag) && statusQ == 8'hA8) |-> $past(sdaOe));

  // R10: clear with stop-request releases everything next cycle
  p_recover_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && ctrlIntClr && ctrlStop && intFlag) |=>
      (!intFlag && !stopQ && !sdaOe && !sclOe && statusQ == 8'hF8));

  // R11: bus error ignores a clear without stop-request
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (intFlag && statusQ == 8'h00 && ctrlWe && ctrlIntClr && !ctrlStop) |=>
      (intFlag && statusQ == 8'h00));
endmodule

bind i2c_tx_slave i2c_tx_slave_chk chk_i (
  .clk(clk), .rstN(rstN), .sclOe(sclOe), .sdaOe(sdaOe),
  .ctrlWe(ctrlWe), .ctrlStop(ctrlStop), .ctrlIntClr(ctrlIntClr),
  .stopQ(stopQ), .statusQ(statusQ), .intFlag(intFlag)
);

// File: tb/i2c_tx_slave_tb_top.sv
module i2c_tx_slave_tb_top;
  localparam logic [6:0] OWN = 7'h5A;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0;
  logic mSclLow = 1'b0, mSdaLow = 1'b0;
  logic sclOe, sdaOe, sclBus, sdaBus;
  logic dataWe = 1'b0, ctrlWe = 1'b0, ctrlAckEn = 1'b0, ctrlStop = 1'b0, ctrlIntClr = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic ackEnQ, stopQ, intFlag;
  logic [7:0] statusQ;

  assign sclBus = !(mSclLow || sclOe);
  assign sdaBus = !(mSdaLow || sdaOe);

  i2c_tx_slave #(.OWN_ADDR(OWN), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus), .sclOe(sclOe), .sdaOe(sdaOe),
    .dataWe(dataWe), .dataIn(dataIn), .ctrlWe(ctrlWe), .ctrlAckEn(ctrlAckEn),
    .ctrlStop(ctrlStop), .ctrlIntClr(ctrlIntClr), .ackEnQ(ackEnQ), .stopQ(stopQ),
    .statusQ(statusQ), .intFlag(intFlag)
  );

  int nChk = 0, nBad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sclHigh();
    mSclLow = 1'b0;
    while (!sclBus) @(negedge clk);
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sclLow();
    mSclLow = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic busStart();
    mSdaLow = 1'b0;
    repeat (2) @(negedge clk);
    sclHigh();
    mSdaLow = 1'b1;
    repeat (HALF) @(negedge clk);
    sclLow();
  endtask

  task automatic busStop();
    mSdaLow = 1'b1;
    repeat (2) @(negedge clk);
    sclHigh();
    mSdaLow = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic writeBit(input logic b);
    mSdaLow = !b;
    repeat (2) @(negedge clk);
    sclHigh();
    sclLow();
  endtask

  task automatic readBit(output logic b);
    mSdaLow = 1'b0;
    repeat (2) @(negedge clk);
    sclHigh();
    b = sdaBus;
    sclLow();
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
  endtask

  task automatic recvByte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
  endtask

  task automatic hostCtrl(input logic ae, input logic st, input logic clr);
    ctrlWe = 1'b1; ctrlAckEn = ae; ctrlStop = st; ctrlIntClr = clr;
    @(negedge clk);
    ctrlWe = 1'b0; ctrlStop = 1'b0; ctrlIntClr = 1'b0;
  endtask

  task automatic hostData(input logic [7:0] v);
    dataWe = 1'b1; dataIn = v;
    @(negedge clk);
    dataWe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic b;
    logic [7:0] got, v;
    logic relOk;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", statusQ, 8'hF8);
    check("R1 flag", intFlag, 0);
    check("R1 oe", {sclOe, sdaOe}, 0);
    check("R1 ctrl", {ackEnQ, stopQ}, 0);

    hostCtrl(1'b1, 1'b0, 1'b0);
    // R2 sweep of every address and direction
    for (int a = 0; a < 128; a++) begin
      for (int rw = 0; rw < 2; rw++) begin
        logic hit;
        hit = (a == int'(OWN)) && (rw == 1);
        busStart();
        sendByte({a[6:0], rw[0]});
        readBit(b);
        check("R2 address ack", b, hit ? 0 : 1);
        if (hit) begin
          check("R3 flag after address", intFlag, 1);
          check("R3 status A8", statusQ, 8'hA8);
          check("R3 scl held", sclOe, 1);
          hostCtrl(1'b1, 1'b1, 1'b1);
          check("R10 released after stop clear", {intFlag, sclOe, sdaOe}, 0);
        end else begin
          check("R2 no flag foreign", {intFlag, statusQ}, {1'b0, 8'hF8});
        end
        busStop();
      end
    end

    // R4 R5: six bytes, last one not acknowledged
    busStart();
    sendByte({OWN, 1'b1});
    readBit(b);
    check("R2 own read ack", b, 0);
    check("R3 status A8", statusQ, 8'hA8);
    for (int i = 0; i < 6; i++) begin
      v = 8'((i * 73 + 11) & 255);
      hostData(v);
      hostCtrl(1'b1, 1'b0, 1'b1);
      check("R3 scl released on clear", {intFlag, sclOe}, 0);
      check("R8 status F8 while clear", statusQ, 8'hF8);
      recvByte(got);
      check("R4 byte MSB first", got, v);
      writeBit(i == 5);
      check("R5 flag", intFlag, 1);
      check("R5 status", statusQ, (i == 5) ? 8'hC0 : 8'hB8);
    end
    hostCtrl(1'b1, 1'b0, 1'b1);
    check("R7 released after C0", {intFlag, sdaOe, sclOe}, 0);
    check("R8 status F8", statusQ, 8'hF8);
    busStop();

    // R6 R7: last byte acknowledged by master
    busStart();
    sendByte({OWN, 1'b1});
    readBit(b);
    check("R7 new transfer ack", b, 0);
    check("R7 status A8", statusQ, 8'hA8);
    hostData(8'h3C);
    hostCtrl(1'b1, 1'b0, 1'b1);
    recvByte(got);
    check("R4 byte", got, 8'h3C);
    writeBit(1'b0);
    check("R5 status B8", statusQ, 8'hB8);
    hostData(8'hC3);
    hostCtrl(1'b0, 1'b0, 1'b1);
    recvByte(got);
    check("R4 last byte", got, 8'hC3);
    writeBit(1'b0);
    check("R6 status C8", statusQ, 8'hC8);
    hostCtrl(1'b0, 1'b0, 1'b1);
    recvByte(got);
    check("R6 all ones", got, 8'hFF);
    writeBit(1'b0);
    check("R6 no flag after extra", {intFlag, statusQ}, {1'b0, 8'hF8});
    busStop();

    // R12 acknowledge disabled
    busStart();
    sendByte({OWN, 1'b1});
    readBit(b);
    check("R12 no ack when disabled", b, 1);
    check("R12 no flag", intFlag, 0);
    busStop();
    hostCtrl(1'b1, 1'b0, 1'b0);

    // R9 R11 R10: START inside address byte
    busStart();
    writeBit(1'b1); writeBit(1'b0); writeBit(1'b1);
    mSdaLow = 1'b0;
    repeat (2) @(negedge clk);
    sclHigh();
    mSdaLow = 1'b1;
    repeat (HALF) @(negedge clk);
    sclLow();
    check("R9 flag on start", intFlag, 1);
    check("R9 status 00", statusQ, 8'h00);
    check("R9 scl held", sclOe, 1);
    hostCtrl(1'b1, 1'b0, 1'b1);
    check("R11 ignored clear", {intFlag, statusQ}, {1'b1, 8'h00});
    hostCtrl(1'b1, 1'b1, 1'b1);
    check("R10 flag and stop cleared", {intFlag, stopQ}, 0);
    check("R10 lines released", {sclOe, sdaOe}, 0);
    check("R10 ackEn kept", ackEnQ, 1);
    check("R10 status F8", statusQ, 8'hF8);
    relOk = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (sdaOe || sclOe) relOk = 1'b0;
    end
    check("R10 no stop driven", relOk, 1);
    busStop();

    // R9: STOP inside a data byte
    busStart();
    sendByte({OWN, 1'b1});
    readBit(b);
    check("R10 serves after recovery", b, 0);
    hostData(8'hFF);
    hostCtrl(1'b1, 1'b0, 1'b1);
    readBit(b); readBit(b); readBit(b);
    mSdaLow = 1'b1;
    repeat (2) @(negedge clk);
    sclHigh();
    mSdaLow = 1'b0;
    repeat (HALF) @(negedge clk);
    check("R9 flag on stop", {intFlag, statusQ}, {1'b1, 8'h00});
    sclLow();
    hostCtrl(1'b1, 1'b1, 1'b1);
    check("R10 recovered", {intFlag, sclOe, sdaOe, stopQ}, 0);
    busStop();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule